// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block steps through the column addresses of one SDRAM read or write burst and times the data strobes that go with them. A controller loads a 12-bit mode word that fixes the burst length, the ordering (linear or bit-swapped), the read latency and an optional one-beat-write policy. It then pulses a start with a column and a direction. The sequencer puts out one column per cycle, starting in the command cycle itself. Each write beat gets a write strobe in its own cycle. Each read beat gets a data-valid strobe a latency later.

A byte-mask input acts on writes in the same cycle and on reads two cycles later. A burst-stop or precharge request halts column issue at once, while read data already in flight is still delivered. A new command may replace a running burst on any cycle.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the mode is length 1, linear order, latency 2, one-beat-write off. `busy`, `colValid`, `wrEn` and `rdValid` are low. A mode word loaded with `modeLoad` takes effect from the next cycle. Its fields are: [2:0] length code (000=1, 001=2, 010=4, 011=8, 111=256); [3] order (0 linear, 1 swapped); [6:4] latency code (010=2, 011=3); [9] one-beat writes.
- R2: A mode word is rejected and the old mode kept if any of these holds: the length code is 100 to 110; the latency code is other than 010 or 011; the length code is 111 with bit 3 set; bits [8:7] or [11:10] are non-zero.
- R3: A mode load while `busy` is high, or in a cycle with `cmdStart` high, is ignored.
- R4: On `cmdStart`, beat 0 issues in the same cycle with `col` = `startCol` and `colValid` high. Further beats follow on consecutive cycles.
- R5: In linear order, beat i has column (start + i) taken modulo the length, kept inside the length-aligned block that holds the start column.
- R6: In swapped order, the low log2(length) bits of beat i are the start column's low bits XOR i. The upper bits are unchanged.
- R7: With length code 111, the burst runs linearly over all 256 columns, wrapping from 255 to 0. It never ends by itself.
- R8: With bit 9 set, a write issues exactly one beat. Reads keep the programmed length.
- R9: A read beat issued in cycle t raises `rdValid` in cycle t + latency.
- R10: `wrEn` is high for a write beat unless `dqm` is high in that same cycle. The column still advances for a masked beat.
- R11: `dqm` high in cycle t suppresses `rdValid` in cycle t+2.
- R12: `stopReq` or `prechReq` in cycle s, without a command, issues no beat in s or later. Read data of beats issued before s still arrives, so latency minus one valid beats follow s.
- R13: A command during a running burst aborts it and starts the new burst at once. A command wins over a stop or precharge request in the same cycle.
- R14: `busy` is high in any cycle in which beats of an earlier command remain to be issued or read data is still pending beyond that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| modeLoad | input | 1 | Load `modeWord` into the mode state |
| modeWord | input | 12 | Mode word |
| cmdStart | input | 1 | Start a burst this cycle |
| cmdWrite | input | 1 | Direction of the command: 1 write, 0 read |
| startCol | input | 8 | First column of the burst |
| stopReq | input | 1 | Burst-stop request |
| prechReq | input | 1 | Precharge-interrupt request |
| dqm | input | 1 | Byte mask for the current cycle |
| col | output | 8 | Column of the current beat, 0 when no beat issues |
| colValid | output | 1 | A beat issues this cycle |
| wrEn | output | 1 | Write beat accepted this cycle |
| rdValid | output | 1 | Read data valid this cycle |
| busy | output | 1 | Earlier burst still issuing or read data pending |

## Verification
The bench covers two kinds of same-cycle event.

The first is a new command arriving while an earlier burst is still issuing columns. The bench issues a read, then a write two cycles later. It judges the result by the column stream switching in that cycle, while the two read beats already issued still produce their delayed valid strobes.

The second is a stop request in the same cycle as a command. The bench asserts both together and expects the command to win with a full burst. It also pulses a mode load in the middle of a burst and checks that the following burst keeps the old length.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int COL_W  = 8;
  localparam int MODE_W = 12;

  typedef struct packed {
    logic [2:0] lenCode;
    logic       interleave;
    logic       cl3;
    logic       wrSingle;
  } modeState_t;

  typedef struct packed {
    logic             issue;
    logic             fresh;
    logic             isWrite;
    logic             interleave;
    logic             cl3;
    logic [COL_W-1:0] wrapMask;
    logic [COL_W-1:0] beatIdx;
  } beatCtl_t;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_col_pkg::*;
#(
  parameter int ColW  = COL_W,
  parameter int ModeW = MODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic [ModeW-1:0] modeWord,
  input  logic             cmdStart,
  input  logic             cmdWrite,
  input  logic             stopReq,
  input  logic             prechReq,
  input  logic             pending,
  output beatCtl_t         ctl,
  output modeState_t       modeQ,
  output logic             running
);
  logic            runQ, wrQ, fullQ;
  logic [ColW-1:0] cntQ, maskQ, cmdMask;
  logic            legal, kill;

  function automatic logic [ColW-1:0] maskFor(input logic [2:0] code);
    case (code)
      3'd0:    maskFor = '0;
      3'd1:    maskFor = ColW'(1);
      3'd2:    maskFor = ColW'(3);
      3'd3:    maskFor = ColW'(7);
      default: maskFor = '1;
    endcase
  endfunction

  always_comb begin
    legal = ((modeWord[2:0] <= 3'd3) || (modeWord[2:0] == 3'd7))
         && ((modeWord[6:4] == 3'd2) || (modeWord[6:4] == 3'd3))
         && !((modeWord[2:0] == 3'd7) && modeWord[3])
         && (modeWord[8:7] == 2'b00) && (modeWord[11:10] == 2'b00);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '{lenCode: 3'd0, interleave: 1'b0, cl3: 1'b0, wrSingle: 1'b0};
    end else if (modeLoad && legal && !runQ && !pending && !cmdStart) begin
      modeQ <= '{lenCode: modeWord[2:0], interleave: modeWord[3],
                 cl3: modeWord[4], wrSingle: modeWord[9]};
    end
  end

  assign cmdMask = (cmdWrite && modeQ.wrSingle) ? '0 : maskFor(modeQ.lenCode);
  assign kill    = (stopReq || prechReq) && !cmdStart;
  assign running = runQ;

  always_comb begin
    ctl.issue      = cmdStart || (runQ && !kill);
    ctl.fresh      = cmdStart;
    ctl.isWrite    = cmdStart ? cmdWrite : wrQ;
    ctl.interleave = modeQ.interleave;
    ctl.cl3        = modeQ.cl3;
    ctl.wrapMask   = cmdStart ? cmdMask : maskQ;
    ctl.beatIdx    = cmdStart ? '0 : cntQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      wrQ   <= 1'b0;
      fullQ <= 1'b0;
      cntQ  <= '0;
      maskQ <= '0;
    end else if (cmdStart) begin
      runQ  <= (cmdMask != '0);
      wrQ   <= cmdWrite;
      fullQ <= (cmdMask == '1);
      cntQ  <= ColW'(1);
      maskQ <= cmdMask;
    end else if (runQ) begin
      if (kill) begin
        runQ <= 1'b0;
      end else begin
        cntQ <= cntQ + 1'b1;
        if ((cntQ == maskQ) && !fullQ) runQ <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_col_pkg::*;
#(
  parameter int ColW  = COL_W,
  parameter int MaxCl = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ColW-1:0] startCol,
  input  logic            dqm,
  input  beatCtl_t        ctl,
  output logic [ColW-1:0] col,
  output logic            colValid,
  output logic            wrEn,
  output logic            rdValid,
  output logic            pending
);
  localparam int DqmLat = 2;

  logic [ColW-1:0]   baseQ, base, offs;
  logic [MaxCl-1:0]  rdPipe;
  logic [DqmLat-1:0] dqmPipe;

  always_ff @(posedge clk) begin
    if (!rstN) baseQ <= '0;
    else if (ctl.fresh) baseQ <= startCol;
  end

  always_comb begin
    base = ctl.fresh ? startCol : baseQ;
    offs = ctl.interleave ? (base ^ ctl.beatIdx) : (base + ctl.beatIdx);
    col  = ctl.issue ? ((base & ~ctl.wrapMask) | (offs & ctl.wrapMask)) : '0;
  end

  assign colValid = ctl.issue;
  assign wrEn     = ctl.issue && ctl.isWrite && !dqm;

  genvar s;
  generate
    for (s = 0; s < MaxCl; s++) begin : g_rdStage
      always_ff @(posedge clk) begin
        if (!rstN) rdPipe[s] <= 1'b0;
        else if (s == 0) rdPipe[s] <= ctl.issue && !ctl.isWrite;
        else rdPipe[s] <= rdPipe[(s == 0) ? 0 : s-1];
      end
    end
    for (s = 0; s < DqmLat; s++) begin : g_dqmStage
      always_ff @(posedge clk) begin
        if (!rstN) dqmPipe[s] <= 1'b0;
        else if (s == 0) dqmPipe[s] <= dqm;
        else dqmPipe[s] <= dqmPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign rdValid = (ctl.cl3 ? rdPipe[2] : rdPipe[1]) && !dqmPipe[DqmLat-1];
  assign pending = ctl.cl3 ? (rdPipe[0] || rdPipe[1]) : rdPipe[0];
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int ColW  = COL_W,
  parameter int ModeW = MODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic [ModeW-1:0] modeWord,
  input  logic             cmdStart,
  input  logic             cmdWrite,
  input  logic [ColW-1:0]  startCol,
  input  logic             stopReq,
  input  logic             prechReq,
  input  logic             dqm,
  output logic [ColW-1:0]  col,
  output logic             colValid,
  output logic             wrEn,
  output logic             rdValid,
  output logic             busy
);
  beatCtl_t   ctl;
  modeState_t modeQ;
  logic       running, pending;
  logic       ctlCl3, ctlWr;

  burst_ctl #(.ColW(ColW), .ModeW(ModeW)) u_ctl (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeWord(modeWord),
    .cmdStart(cmdStart), .cmdWrite(cmdWrite), .stopReq(stopReq),
    .prechReq(prechReq), .pending(pending), .ctl(ctl), .modeQ(modeQ),
    .running(running)
  );

  burst_dp #(.ColW(ColW)) u_dp (
    .clk(clk), .rstN(rstN), .startCol(startCol), .dqm(dqm), .ctl(ctl),
    .col(col), .colValid(colValid), .wrEn(wrEn), .rdValid(rdValid),
    .pending(pending)
  );

  assign busy   = running || pending;
  assign ctlCl3 = ctl.cl3;
  assign ctlWr  = ctl.isWrite;
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk
  import burst_col_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cmdStart,
  input logic       stopReq,
  input logic       prechReq,
  input logic       dqm,
  input logic       colValid,
  input logic       wrEn,
  input logic       rdValid,
  input logic       busy,
  input logic       ctlCl3,
  input logic       ctlWr,
  input modeState_t modeQ
);
  assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(modeQ));

  assert_wr_needs_beat_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> colValid);

  assert_wr_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    dqm |-> !wrEn);

  assert_rd_latency2_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !ctlCl3) |-> $past(colValid && !ctlWr, 2));

  assert_rd_latency3_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && ctlCl3) |-> $past(colValid && !ctlWr, 3));

  assert_stop_halts_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((stopReq || prechReq) && !cmdStart) |-> !colValid);

  assert_idle_quiet_R14: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdStart) |-> !colValid);
endmodule

bind burst_col_gen burst_col_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .stopReq(stopReq),
  .prechReq(prechReq), .dqm(dqm), .colValid(colValid), .wrEn(wrEn),
  .rdValid(rdValid), .busy(busy), .ctlCl3(ctlCl3), .ctlWr(ctlWr),
  .modeQ(modeQ)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int ClkPeriod = 10;
  localparam int WatchLimit = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeLoad = 1'b0;
  logic [11:0] modeWord = '0;
  logic        cmdStart = 1'b0, cmdWrite = 1'b0;
  logic [7:0]  startCol = '0;
  logic        stopReq = 1'b0, prechReq = 1'b0, dqm = 1'b0;
  logic [7:0]  col;
  logic        colValid, wrEn, rdValid, busy;

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;
  string curReq = "R1";
  int colCycQ[$], colValQ[$], wrCycQ[$], wrValQ[$], rdCycQ[$];

  int maskB = 0, clB = 2;
  bit interB = 0, wsB = 0, fullB = 0;

  burst_col_gen u_dut (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeWord(modeWord),
    .cmdStart(cmdStart), .cmdWrite(cmdWrite), .startCol(startCol),
    .stopReq(stopReq), .prechReq(prechReq), .dqm(dqm), .col(col),
    .colValid(colValid), .wrEn(wrEn), .rdValid(rdValid), .busy(busy)
  );

  always #(ClkPeriod/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int expCol(input int base, input int i, input int mask, input bit inter);
    int off;
    off = inter ? (base ^ i) : (base + i);
    return ((base & ~mask) | (off & mask)) & 255;
  endfunction

  function automatic bit legalWord(input logic [11:0] w);
    return ((w[2:0] <= 3'd3) || (w[2:0] == 3'd7)) && ((w[6:4] == 3'd2) || (w[6:4] == 3'd3))
        && !((w[2:0] == 3'd7) && w[3]) && (w[8:7] == 2'b00) && (w[11:10] == 2'b00);
  endfunction

  // Monitor: pops expected items as the design produces events
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (colValid) begin
        if (colCycQ.size() == 0) check({curReq, " unexpected beat"}, 1, 0);
        else begin
          check({curReq, " beat cycle"}, cyc, colCycQ.pop_front());
          check({curReq, " beat column"}, col, colValQ.pop_front());
        end
      end
      if (wrEn) begin
        if (wrCycQ.size() == 0) check({curReq, " unexpected write strobe"}, 1, 0);
        else begin
          check({curReq, " write cycle"}, cyc, wrCycQ.pop_front());
          check({curReq, " write column"}, col, wrValQ.pop_front());
        end
      end
      if (rdValid) begin
        if (rdCycQ.size() == 0) check({curReq, " unexpected read valid"}, 1, 0);
        else check({curReq, " read valid cycle"}, cyc, rdCycQ.pop_front());
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > WatchLimit && !done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WatchLimit);
      finishRun();
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic loadMode(input logic [11:0] w);
    modeWord = w; modeLoad = 1'b1;
    @(posedge clk); #1;
    modeLoad = 1'b0;
    if (legalWord(w)) begin
      interB = w[3]; clB = (w[6:4] == 3'd3) ? 3 : 2; wsB = w[9];
      fullB = (w[2:0] == 3'd7);
      maskB = fullB ? 255 : ((1 << w[2:0]) - 1);
    end
    idle(1);
  endtask

  // Driver: pushes expected items, drives the burst, checks busy each cycle (R14)
  task automatic runBurst(input bit wr, input int sc, input int stopAt, input bit usePre,
                          input logic [31:0] dqmBits, input int loadAt);
    int len, nb, runEnd, c0, kMax;
    bit stopped, expBusy;
    c0 = cyc;
    len = (wr && wsB) ? 1 : (fullB ? (1 << 30) : maskB + 1);
    stopped = (stopAt >= 0) && (stopAt < len);
    nb = stopped ? stopAt : len;
    runEnd = stopped ? stopAt : len - 1;
    for (int i = 0; i < nb; i++) begin
      colCycQ.push_back(c0 + i);
      colValQ.push_back(expCol(sc, i, maskB & ((wr && wsB) ? 0 : 255), interB));
      if (wr && !(i < 32 && dqmBits[i])) begin
        wrCycQ.push_back(c0 + i);
        wrValQ.push_back(expCol(sc, i, maskB & ((wr && wsB) ? 0 : 255), interB));
      end
      if (!wr && !((i + clB - 2) < 32 && dqmBits[i + clB - 2])) rdCycQ.push_back(c0 + i + clB);
    end
    kMax = nb + clB + 2;
    for (int k = 0; k < kMax; k++) begin
      cmdStart = (k == 0); cmdWrite = wr; startCol = 8'(sc);
      stopReq = (k == stopAt) && !usePre; prechReq = (k == stopAt) && usePre;
      dqm = (k < 32) ? dqmBits[k] : 1'b0;
      modeLoad = (k == loadAt); modeWord = 12'h020;
      @(negedge clk);
      expBusy = ((k >= 1) && (k <= runEnd)) || (!wr && (k >= 1) && (k <= nb + clB - 2));
      check("R14 busy", busy, expBusy);
      @(posedge clk); #1;
    end
    cmdStart = 0; stopReq = 0; prechReq = 0; dqm = 0; modeLoad = 0;
    idle(1);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset colValid", colValid, 0);
    check("R1 reset wrEn", wrEn, 0);
    check("R1 reset rdValid", rdValid, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    idle(1);

    curReq = "R1/R4"; runBurst(1, 8'h35, -1, 0, 0, -1);
    curReq = "R9";    runBurst(0, 8'h35, -1, 0, 0, -1);

    curReq = "R5"; loadMode(12'h022);
    runBurst(1, 8'h46, -1, 0, 0, -1);
    runBurst(0, 8'hB3, -1, 0, 0, -1);

    curReq = "R6"; loadMode(12'h03B);
    runBurst(0, 8'h5D, -1, 0, 0, -1);

    curReq = "R2";
    loadMode(12'h02F); loadMode(12'h043); loadMode(12'h025); loadMode(12'h0BB);
    runBurst(1, 8'h13, -1, 0, 0, -1);

    curReq = "R10"; runBurst(1, 8'h70, -1, 0, 32'h25, -1);
    curReq = "R11"; runBurst(0, 8'h40, -1, 0, 32'h9, -1);

    curReq = "R8"; loadMode(12'h232);
    runBurst(1, 8'h29, -1, 0, 0, -1);
    runBurst(0, 8'h29, -1, 0, 0, -1);

    curReq = "R12"; loadMode(12'h033);
    runBurst(0, 8'h20, 3, 1, 0, -1);
    runBurst(1, 8'h20, 2, 0, 0, -1);

    curReq = "R7"; loadMode(12'h027);
    runBurst(0, 8'hFC, 7, 0, 0, -1);
    runBurst(1, 8'h80, 300, 1, 0, -1);

    curReq = "R3"; loadMode(12'h023);
    runBurst(0, 8'h11, -1, 0, 0, 2);
    runBurst(1, 8'hA5, -1, 0, 0, -1);

    // R13: a write aborts a running read; stop in the same cycle loses
    curReq = "R13"; loadMode(12'h022);
    begin
      int c0;
      c0 = cyc;
      colCycQ.push_back(c0);     colValQ.push_back(8'h60);
      colCycQ.push_back(c0 + 1); colValQ.push_back(8'h61);
      rdCycQ.push_back(c0 + 2);  rdCycQ.push_back(c0 + 3);
      for (int i = 0; i < 4; i++) begin
        colCycQ.push_back(c0 + 2 + i); colValQ.push_back(expCol(8'h91, i, 3, 0));
        wrCycQ.push_back(c0 + 2 + i);  wrValQ.push_back(expCol(8'h91, i, 3, 0));
      end
      cmdStart = 1; cmdWrite = 0; startCol = 8'h60;
      @(posedge clk); #1;
      cmdStart = 0;
      @(posedge clk); #1;
      cmdStart = 1; cmdWrite = 1; startCol = 8'h91; stopReq = 1;
      @(posedge clk); #1;
      cmdStart = 0; stopReq = 0;
      idle(8);
    end

    idle(4);
    check("R4 leftover beats", colCycQ.size(), 0);
    check("R10 leftover writes", wrCycQ.size(), 0);
    check("R9 leftover reads", rdCycQ.size(), 0);
    finishRun();
  end
endmodule